// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Status Flags

This block holds the result registers and status flags that sit behind a scanning, multi-channel analog-to-digital converter. Each completed conversion arrives as a one-cycle pulse carrying a channel number and a result. The block stores the result in that channel's data register and in a shared most-recent-result register. It then updates four kinds of flag: a per-channel conversion-complete bit, a per-channel overrun bit, a global data-ready bit and a global overrun bit.

Software-side accesses arrive as single-cycle read strobes for a channel data register, the most-recent-result register and the status word. Channel enable and disable writes arrive as bit masks. Every flag is a single register with one next-state equation, so several of these events can land in the same clock cycle and still produce the correct outcome. Examples are a read, a disable and a conversion completion together. No clear is ever steered to the wrong channel.

Top module: `adc_flag_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all enables, all completion and overrun flags, data-ready, global overrun and the read-valid output.
- R2: An enable write sets the masked bits of `chan_en_o` and a disable write clears them from the next cycle. When one bit is both enabled and disabled in the same cycle, the disable wins.
- R3: A completion on an enabled channel sets that channel's completion bit and data-ready on the next cycle. It also stores the result both in the channel register and, together with the channel number, in the most-recent-result register.
- R4: A completion is ignored completely if its channel is disabled, including a disable written in the same cycle. It changes no flag and no stored result.
- R5: A channel data read clears only that channel's completion bit, even when another channel completes in the same cycle. If the same channel completes in that cycle, the bit stays set.
- R6: A most-recent-result read clears data-ready and the completion bit of the channel whose result it holds. A completion in the same cycle sets its own bits, and that set wins.
- R7: A channel's overrun bit is set when that channel completes while its completion bit is set and not being cleared by a read in the same cycle.
- R8: Global overrun is set when an accepted completion arrives while data-ready is set and no most-recent-result read happens in that cycle. This holds even when a channel read or a disable happens in the same cycle.
- R9: A status read clears all overrun bits and global overrun, including any overrun that would be set in that cycle. It leaves completion bits and data-ready unchanged.
- R10: One cycle after any read strobe, `rd_valid_o` is 1 and `rd_data_o` holds the value from before that cycle's events. A status read wins over a most-recent read, which wins over a channel read. The status read returns global overrun in bit 17, data-ready in bit 16, overrun in bits 15:8 and completion in bits 7:0. The most-recent read returns the channel in bits 12:10 and the result in bits 9:0. A channel read returns the result in bits 9:0. With no strobe, `rd_valid_o` is 0.
- R11: If a channel's completion bit was cleared by a read, its next completion sets the bit again without raising overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done_i | input | 1 | Conversion-complete pulse |
| conv_ch_i | input | 3 | Channel of the completed conversion |
| conv_data_i | input | 10 | Conversion result |
| en_wr_i | input | 1 | Enable write strobe |
| en_mask_i | input | 8 | Channels to enable |
| dis_wr_i | input | 1 | Disable write strobe |
| dis_mask_i | input | 8 | Channels to disable |
| rd_chan_i | input | 1 | Channel data register read strobe |
| rd_chan_sel_i | input | 3 | Channel being read |
| rd_last_i | input | 1 | Most-recent-result read strobe |
| rd_status_i | input | 1 | Status word read strobe |
| chan_en_o | output | 8 | Channel enable state |
| eoc_o | output | 8 | Per-channel completion flags |
| ovre_o | output | 8 | Per-channel overrun flags |
| drdy_o | output | 1 | Global data-ready flag |
| govre_o | output | 1 | Global overrun flag |
| rd_valid_o | output | 1 | Read data valid, one cycle after a strobe |
| rd_data_o | output | 18 | Read data |

## Verification
The bench drives coincident events that trap a careless implementation:
- A channel read landing together with another channel's completion. A design that decodes the clear from the wrong channel number would drop the wrong completion bit.
- A status read landing with a fresh overrun. A design that let the set win would leave an overrun flag standing after the read.
- A disable landing with the same channel's completion. A leaky design would raise that channel's completion bit and overwrite its stored result.
- A read and a completion on the same channel, and a most-recent read paired with a new completion. Reversing the set/clear priority shows up there as a lost completion bit, a false overrun, or data-ready dropping while data is waiting.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;
  localparam int DEF_N_CH = 8;
  localparam int DEF_DW   = 10;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CHAN = 2'd1,
    SRC_LAST = 2'd2,
    SRC_STAT = 2'd3
  } rd_src_e;
endpackage

// File: rtl/adc_chan_enable.sv
module adc_chan_enable #(
  parameter int N_CH = 8,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_wr,
  input  logic [N_CH-1:0] en_mask,
  input  logic            dis_wr,
  input  logic [N_CH-1:0] dis_mask,
  input  logic            done,
  input  logic [CH_W-1:0] done_ch,
  output logic [N_CH-1:0] en_q,
  output logic            accept,
  output logic [N_CH-1:0] accept_vec
);
  logic [N_CH-1:0] dis_eff;
  logic [N_CH-1:0] en_eff;

  assign dis_eff = dis_wr ? dis_mask : '0;
  assign en_eff  = en_wr  ? en_mask  : '0;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | en_eff) & ~dis_eff;
  end

  // a disable in the same cycle suppresses the completion
  genvar g;
  generate
    for (g = 0; g < N_CH; g++) begin : g_acc
      assign accept_vec[g] = done && (done_ch == CH_W'(g)) && en_q[g] && !dis_eff[g];
    end
  endgenerate

  assign accept = |accept_vec;
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int N_CH = 8,
  parameter int DW   = 10,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [CH_W-1:0] rd_ch,
  output logic [DW-1:0]   rd_q,
  output logic [DW-1:0]   last_data_q,
  output logic [CH_W-1:0] last_ch_q
);
  logic [DW-1:0] mem [N_CH];

  // plain write port and registered read port, read-first
  always_ff @(posedge clk) begin
    if (accept) mem[wr_ch] <= wr_data;
    if (rd_en)  rd_q <= mem[rd_ch];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_data_q <= '0;
      last_ch_q   <= '0;
    end else if (accept) begin
      last_data_q <= wr_data;
      last_ch_q   <= wr_ch;
    end
  end
endmodule

// File: rtl/adc_flag_core.sv
module adc_flag_core #(
  parameter int N_CH = 8,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] set_vec,
  input  logic            rd_chan,
  input  logic [CH_W-1:0] rd_ch,
  input  logic            rd_last,
  input  logic [CH_W-1:0] last_ch,
  input  logic            rd_status,
  output logic [N_CH-1:0] eoc_q,
  output logic [N_CH-1:0] ovre_q,
  output logic            drdy_q,
  output logic            govre_q
);
  logic [N_CH-1:0] clr_vec;
  logic [N_CH-1:0] ovre_hit;
  logic            any_set;
  logic            govre_hit;

  genvar g;
  generate
    for (g = 0; g < N_CH; g++) begin : g_clr
      assign clr_vec[g] = (rd_chan && rd_ch == CH_W'(g)) ||
                          (rd_last && last_ch == CH_W'(g));
    end
  endgenerate

  always_comb begin
    any_set   = |set_vec;
    ovre_hit  = set_vec & eoc_q & ~clr_vec;
    govre_hit = any_set && drdy_q && !rd_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_q   <= '0;
      ovre_q  <= '0;
      drdy_q  <= 1'b0;
      govre_q <= 1'b0;
    end else begin
      eoc_q  <= (eoc_q & ~clr_vec) | set_vec;
      drdy_q <= (drdy_q && !rd_last) || any_set;
      if (rd_status) begin
        ovre_q  <= '0;
        govre_q <= 1'b0;
      end else begin
        ovre_q  <= ovre_q | ovre_hit;
        govre_q <= govre_q || govre_hit;
      end
    end
  end
endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl
  import adc_flag_pkg::*;
#(
  parameter int N_CH = DEF_N_CH,
  parameter int DW   = DEF_DW,
  parameter int CH_W = $clog2(N_CH),
  parameter int RD_W = (2*N_CH+2 > CH_W+DW) ? 2*N_CH+2 : CH_W+DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            conv_done_i,
  input  logic [CH_W-1:0] conv_ch_i,
  input  logic [DW-1:0]   conv_data_i,
  input  logic            en_wr_i,
  input  logic [N_CH-1:0] en_mask_i,
  input  logic            dis_wr_i,
  input  logic [N_CH-1:0] dis_mask_i,
  input  logic            rd_chan_i,
  input  logic [CH_W-1:0] rd_chan_sel_i,
  input  logic            rd_last_i,
  input  logic            rd_status_i,
  output logic [N_CH-1:0] chan_en_o,
  output logic [N_CH-1:0] eoc_o,
  output logic [N_CH-1:0] ovre_o,
  output logic            drdy_o,
  output logic            govre_o,
  output logic            rd_valid_o,
  output logic [RD_W-1:0] rd_data_o
);
  localparam int STAT_W = 2*N_CH + 2;
  localparam int LAST_W = CH_W + DW;

  logic            accept;
  logic [N_CH-1:0] accept_vec;
  logic [DW-1:0]   chan_rd_q;
  logic [DW-1:0]   last_data;
  logic [CH_W-1:0] last_ch;
  rd_src_e         src_q;
  logic [RD_W-1:0] snap_q;

  adc_chan_enable #(.N_CH(N_CH), .CH_W(CH_W)) u_en (
    .clk        (clk),
    .rst        (rst),
    .en_wr      (en_wr_i),
    .en_mask    (en_mask_i),
    .dis_wr     (dis_wr_i),
    .dis_mask   (dis_mask_i),
    .done       (conv_done_i),
    .done_ch    (conv_ch_i),
    .en_q       (chan_en_o),
    .accept     (accept),
    .accept_vec (accept_vec)
  );

  adc_result_store #(.N_CH(N_CH), .DW(DW), .CH_W(CH_W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .wr_ch       (conv_ch_i),
    .wr_data     (conv_data_i),
    .rd_en       (rd_chan_i),
    .rd_ch       (rd_chan_sel_i),
    .rd_q        (chan_rd_q),
    .last_data_q (last_data),
    .last_ch_q   (last_ch)
  );

  adc_flag_core #(.N_CH(N_CH), .CH_W(CH_W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (accept_vec),
    .rd_chan   (rd_chan_i),
    .rd_ch     (rd_chan_sel_i),
    .rd_last   (rd_last_i),
    .last_ch   (last_ch),
    .rd_status (rd_status_i),
    .eoc_q     (eoc_o),
    .ovre_q    (ovre_o),
    .drdy_q    (drdy_o),
    .govre_q   (govre_o)
  );

  // read return: status over most-recent over channel
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_NONE;
      snap_q <= '0;
    end else begin
      if (rd_status_i)    src_q <= SRC_STAT;
      else if (rd_last_i) src_q <= SRC_LAST;
      else if (rd_chan_i) src_q <= SRC_CHAN;
      else                src_q <= SRC_NONE;
      if (rd_status_i)
        snap_q <= RD_W'(STAT_W'({govre_o, drdy_o, ovre_o, eoc_o}));
      else if (rd_last_i)
        snap_q <= RD_W'(LAST_W'({last_ch, last_data}));
    end
  end

  always_comb begin
    rd_valid_o = (src_q != SRC_NONE);
    case (src_q)
      SRC_CHAN: rd_data_o = RD_W'(chan_rd_q);
      SRC_LAST,
      SRC_STAT: rd_data_o = snap_q;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_flag_ctrl_chk.sv
module adc_flag_ctrl_chk #(
  parameter int N_CH = 8,
  parameter int DW   = 10,
  parameter int CH_W = 3,
  parameter int RD_W = 18
) (
  input logic            clk,
  input logic            rst,
  input logic            conv_done_i,
  input logic [CH_W-1:0] conv_ch_i,
  input logic [DW-1:0]   conv_data_i,
  input logic            en_wr_i,
  input logic [N_CH-1:0] en_mask_i,
  input logic            dis_wr_i,
  input logic [N_CH-1:0] dis_mask_i,
  input logic            rd_chan_i,
  input logic [CH_W-1:0] rd_chan_sel_i,
  input logic            rd_last_i,
  input logic            rd_status_i,
  input logic [N_CH-1:0] chan_en_o,
  input logic [N_CH-1:0] eoc_o,
  input logic [N_CH-1:0] ovre_o,
  input logic            drdy_o,
  input logic            govre_o,
  input logic            rd_valid_o,
  input logic [RD_W-1:0] rd_data_o
);
  genvar g;
  generate
    for (g = 0; g < N_CH; g++) begin : g_ch
      AST_EOC_RISE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc_o[g]) |-> $past(conv_done_i && conv_ch_i == CH_W'(g) && chan_en_o[g] && !(dis_wr_i && dis_mask_i[g]))); // R4
      AST_EOC_FALL_OWN_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc_o[g]) |-> ($past(rd_chan_i && rd_chan_sel_i == CH_W'(g)) || $past(rd_last_i))); // R5
      AST_OVRE_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovre_o[g]) |-> $past(eoc_o[g] && conv_done_i && conv_ch_i == CH_W'(g))); // R7
    end
  endgenerate

  AST_DRDY_FALL_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(drdy_o) |-> $past(rd_last_i)); // R6
  AST_GOVRE_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(govre_o) |-> $past(drdy_o && conv_done_i)); // R8
  AST_STATUS_CLEARS_OVR: assert property (@(posedge clk) disable iff (rst)
    rd_status_i |=> (ovre_o == '0 && !govre_o)); // R9
  AST_RD_VALID_AFTER: assert property (@(posedge clk) disable iff (rst)
    (rd_status_i || rd_last_i || rd_chan_i) |=> rd_valid_o); // R10
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(rd_status_i || rd_last_i || rd_chan_i) |=> !rd_valid_o); // R10
  AST_STATUS_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    rd_status_i |=> rd_data_o[2*N_CH+1:0] == $past({govre_o, drdy_o, ovre_o, eoc_o})); // R10
endmodule

bind adc_flag_ctrl adc_flag_ctrl_chk #(.N_CH(N_CH), .DW(DW), .CH_W(CH_W), .RD_W(RD_W)) u_chk (.*);

// File: tb/adc_flag_ctrl_test.sv
`timescale 1ns/1ps
module adc_flag_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        conv_done_i;
  logic [2:0]  conv_ch_i;
  logic [9:0]  conv_data_i;
  logic        en_wr_i;
  logic [7:0]  en_mask_i;
  logic        dis_wr_i;
  logic [7:0]  dis_mask_i;
  logic        rd_chan_i;
  logic [2:0]  rd_chan_sel_i;
  logic        rd_last_i;
  logic        rd_status_i;
  logic [7:0]  chan_en_o;
  logic [7:0]  eoc_o;
  logic [7:0]  ovre_o;
  logic        drdy_o;
  logic        govre_o;
  logic        rd_valid_o;
  logic [17:0] rd_data_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  adc_flag_ctrl uut (.*);

  typedef struct packed {
    logic       ev;
    logic [2:0] ech;
    logic [9:0] edat;
    logic [7:0] ens;
    logic [7:0] dis;
    logic       rc;
    logic [2:0] rch;
    logic       rl;
    logic       rs;
    logic [7:0] xeoc;
    logic [7:0] xovre;
    logic       xdrdy;
    logic       xgovre;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b0,3'd0,10'h000,8'h0F,8'h00,1'b0,3'd0,1'b0,1'b0, 8'h00,8'h00,1'b0,1'b0}, // 0  R2 enable 0-3
    '{1'b1,3'd1,10'h011,8'h00,8'h00,1'b0,3'd0,1'b0,1'b0, 8'h02,8'h00,1'b1,1'b0}, // 1  R3
    '{1'b1,3'd2,10'h022,8'h00,8'h00,1'b0,3'd0,1'b0,1'b0, 8'h06,8'h00,1'b1,1'b1}, // 2  R8
    '{1'b0,3'd0,10'h000,8'h00,8'h00,1'b0,3'd0,1'b0,1'b1, 8'h06,8'h00,1'b1,1'b0}, // 3  R9
    '{1'b1,3'd1,10'h033,8'h00,8'h00,1'b0,3'd0,1'b0,1'b0, 8'h06,8'h02,1'b1,1'b1}, // 4  R7 R8
    '{1'b1,3'd3,10'h044,8'h00,8'h00,1'b0,3'd0,1'b0,1'b1, 8'h0E,8'h00,1'b1,1'b0}, // 5  R9 clear beats set
    '{1'b1,3'd2,10'h055,8'h00,8'h00,1'b1,3'd1,1'b0,1'b0, 8'h0C,8'h04,1'b1,1'b1}, // 6  R5 R7 R8
    '{1'b0,3'd0,10'h000,8'h00,8'h00,1'b1,3'd0,1'b1,1'b0, 8'h08,8'h04,1'b0,1'b1}, // 7  R6
    '{1'b1,3'd5,10'h0EE,8'h00,8'h00,1'b0,3'd0,1'b0,1'b0, 8'h08,8'h04,1'b0,1'b1}, // 8  R4 never enabled
    '{1'b1,3'd3,10'h0FF,8'h00,8'h08,1'b0,3'd0,1'b0,1'b0, 8'h08,8'h04,1'b0,1'b1}, // 9  R4 same-cycle disable
    '{1'b1,3'd0,10'h066,8'h00,8'h00,1'b1,3'd3,1'b0,1'b0, 8'h01,8'h04,1'b1,1'b1}, // 10 R5
    '{1'b0,3'd0,10'h000,8'h00,8'h00,1'b0,3'd0,1'b0,1'b1, 8'h01,8'h00,1'b1,1'b0}, // 11 R9
    '{1'b0,3'd0,10'h000,8'h00,8'h00,1'b1,3'd0,1'b0,1'b0, 8'h00,8'h00,1'b1,1'b0}, // 12 R5
    '{1'b1,3'd0,10'h077,8'h00,8'h00,1'b0,3'd0,1'b0,1'b0, 8'h01,8'h00,1'b1,1'b1}, // 13 R11
    '{1'b1,3'd0,10'h088,8'h00,8'h00,1'b1,3'd0,1'b0,1'b0, 8'h01,8'h00,1'b1,1'b1}, // 14 R5 R7 set wins, no overrun
    '{1'b1,3'd1,10'h099,8'h00,8'h00,1'b0,3'd0,1'b1,1'b0, 8'h02,8'h00,1'b1,1'b1}, // 15 R6
    '{1'b1,3'd2,10'h0AA,8'h20,8'h20,1'b0,3'd0,1'b0,1'b0, 8'h06,8'h00,1'b1,1'b1}, // 16 R2 disable wins
    '{1'b0,3'd0,10'h000,8'h00,8'h00,1'b0,3'd0,1'b0,1'b1, 8'h06,8'h00,1'b1,1'b0}  // 17 R9
  };

  task automatic idle_inputs();
    conv_done_i = 1'b0; conv_ch_i = '0; conv_data_i = '0;
    en_wr_i = 1'b0; en_mask_i = '0; dis_wr_i = 1'b0; dis_mask_i = '0;
    rd_chan_i = 1'b0; rd_chan_sel_i = '0; rd_last_i = 1'b0; rd_status_i = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    conv_done_i = v.ev; conv_ch_i = v.ech; conv_data_i = v.edat;
    en_wr_i = |v.ens; en_mask_i = v.ens;
    dis_wr_i = |v.dis; dis_mask_i = v.dis;
    rd_chan_i = v.rc; rd_chan_sel_i = v.rch; rd_last_i = v.rl; rd_status_i = v.rs;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    vec_t v;
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check({chan_en_o, eoc_o, ovre_o, drdy_o, govre_o, rd_valid_o} == '0, "R1 reset",
          {chan_en_o, eoc_o, ovre_o, drdy_o, govre_o, rd_valid_o}, 0);

    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      apply(v);
      check({eoc_o, ovre_o, drdy_o, govre_o} == {v.xeoc, v.xovre, v.xdrdy, v.xgovre},
            $sformatf("row %0d flags (R2-R9 R11)", i),
            {eoc_o, ovre_o, drdy_o, govre_o}, {v.xeoc, v.xovre, v.xdrdy, v.xgovre});
    end

    // R2: channels 0-2 left, 3 disabled, 5 enable+disable same cycle
    check(chan_en_o == 8'h07, "R2 enables", chan_en_o, 8'h07);

    // R10 status word
    v = '0; v.rs = 1'b1; apply(v);
    check(rd_valid_o && rd_data_o == 18'h10006, "R10 status read", {rd_valid_o, rd_data_o}, {1'b1, 18'h10006});

    // R3 stored channel result
    v = '0; v.rc = 1'b1; v.rch = 3'd1; apply(v);
    check(rd_valid_o && rd_data_o == 18'h00099, "R3 channel 1 data", rd_data_o, 18'h00099);

    // R4 ignored completion left channel 3 data alone
    v = '0; v.rc = 1'b1; v.rch = 3'd3; apply(v);
    check(rd_data_o == 18'h00044, "R4 channel 3 data kept", rd_data_o, 18'h00044);

    // R10 priority and pre-cycle value with concurrent completion
    v = '0; v.rc = 1'b1; v.rch = 3'd2; v.rl = 1'b1; v.ev = 1'b1; v.ech = 3'd2; v.edat = 10'h0BB; apply(v);
    check(rd_valid_o && rd_data_o == 18'h008AA, "R10 last read priority", rd_data_o, 18'h008AA);

    // R3 new channel 2 result
    v = '0; v.rc = 1'b1; v.rch = 3'd2; apply(v);
    check(rd_data_o == 18'h000BB, "R3 channel 2 new data", rd_data_o, 18'h000BB);

    // R10 no strobe
    v = '0; apply(v);
    check(!rd_valid_o, "R10 idle valid low", rd_valid_o, 0);

    // R1 reset clears again
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check({chan_en_o, eoc_o, drdy_o} == '0, "R1 reset after activity", {chan_en_o, eoc_o, drdy_o}, 0);

    finish_run();
  end
endmodule